// File: doc/BRIEF.md
# I2C 16-bit quasi-bidirectional port expander

This block is an I2C slave that owns sixteen general-purpose pins, grouped as two 8-bit ports. It has no direction register. A pin whose latch holds 0 is pulled low. A pin whose latch holds 1 is released to a weak pull-up, and an external source can then drive it, so the pin works as an input. After reset every latch is 1, so every pin starts as an input.

A write transaction carries data bytes in pairs. The first byte of each pair goes to port 0 and the second to port 1. Both ports change together once the second byte has been acknowledged. A read transaction returns the sampled pin levels in the same byte order, and repeats the pair for as long as the master acknowledges.

When a pin's latch goes from 0 to 1, the block raises a strong pull-up enable for that pin. The enable drops at the next falling edge of SCL. The bus inputs are oversampled by the system clock, and all bus and pin drives are open-drain enables.

Top module: `qpx_expander`

## Requirements
- R1: While reset is high and in the cycle after it, sda_oe is 0, pin_pull_low is all 0 (all latches 1) and pin_boost is all 0.
- R2: The slave address is {4'b0100, adr_sel[2:0]}, followed by a read/write bit (1 = read). A matching address is acknowledged by pulling SDA low. A non-matching address gets no acknowledge, and the bytes that follow it leave the ports unchanged.
- R3: In a write, a completed pair (first byte b0, second byte b1) sets the latches to {b1, b0}. Bit i of the latches drives pin i, and pin_pull_low equals the inverted latches.
- R4: After only the first byte of a pair has been acknowledged, the ports keep their previous value.
- R5: A write may carry any number of pairs, and each completed pair overwrites the last. A trailing unpaired byte followed by STOP is discarded.
- R6: In a read, the bytes returned are pin_i[7:0], then pin_i[15:8], then again pin_i[7:0] and so on, MSB first. The pins are sampled at the SCL falling edge that ends the preceding acknowledge bit.
- R7: A commit raises pin_boost on each bit that goes from latch 0 to latch 1, and only on those bits. The next SCL falling edge clears pin_boost.
- R8: A repeated START aborts the transaction in progress and discards an incomplete pair.
- R9: Asserting reset in the middle of a transaction releases SDA and returns all latches to 1.
- R10: Writing 1 to a pin releases it, and a later read returns the level that an external source drives onto that pin.
- R11: When the master does not acknowledge a read byte, the block releases SDA and stops sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| adr_sel | input | 3 | Low three bits of the slave address |
| pin_i | input | 16 | Sensed pin levels |
| sda_oe | output | 1 | Pull SDA low when 1 |
| pin_pull_low | output | 16 | Pull each pin low when 1 |
| pin_boost | output | 16 | Strong pull-up enable for each pin |

## Verification
Write traffic uses several kinds of bursts:
- a single pair, checked between its two bytes and after it;
- multi-pair bursts that raise, lower and keep latch bits, which shows whether the boost marks only the 0-to-1 transitions;
- a burst that ends on an odd byte;
- a burst cut short by a repeated START.

Reads use a pin pattern with a different value on each port and continue past one pair, so a swapped byte order and a missing repeat look different. A wrong address and a reset in the middle of a byte check that the ports stay put or return to all ones, as each case requires.

// File: rtl/qpx_pkg.sv
package qpx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } qpx_state_e;
endpackage

// File: rtl/qpx_sync.sv
module qpx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '1;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qpx_i2c_slave.sv
module qpx_i2c_slave #(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 3,
  parameter logic [BYTE_W-2-SEL_W:0] ADDR_HI = 'b0100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl,
  input  logic                sda,
  input  logic [SEL_W-1:0]    adr_sel,
  input  logic [2*BYTE_W-1:0] pin_lvl,
  output logic                sda_oe,
  output logic                wr_stb,
  output logic [2*BYTE_W-1:0] wr_data,
  output logic                scl_fall
);
  import qpx_pkg::*;
  localparam int CW = $clog2(BYTE_W + 1);

  qpx_state_e        state;
  logic              scl_q, sda_q, rw, half, mack;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sh, lo_byte, tx;
  logic              scl_rise, start, stop;
  logic [BYTE_W-1:0] pin_lo, pin_hi;

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start    = scl & scl_q & sda_q & ~sda;
  assign stop     = scl & scl_q & ~sda_q & sda;
  assign pin_lo   = pin_lvl[BYTE_W-1:0];
  assign pin_hi   = pin_lvl[2*BYTE_W-1:BYTE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_data <= '1;
      rw      <= 1'b0;
      half    <= 1'b0;
      mack    <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      lo_byte <= '0;
      tx      <= '0;
    end else begin
      scl_q  <= scl;
      sda_q  <= sda;
      wr_stb <= 1'b0;
      if (start) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        half   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda};
              cnt <= cnt + CW'(1);
            end else if (scl_fall && cnt == CW'(BYTE_W)) begin
              if (sh[BYTE_W-1:1] == {ADDR_HI, adr_sel}) begin
                rw     <= sh[0];
                sda_oe <= 1'b1;
                state  <= ST_AACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                tx     <= pin_lo;
                sda_oe <= ~pin_lo[BYTE_W-1];
                state  <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WDAT;
              end
            end
          end
          ST_WDAT: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda};
              cnt <= cnt + CW'(1);
            end else if (scl_fall && cnt == CW'(BYTE_W)) begin
              sda_oe <= 1'b1;
              state  <= ST_WACK;
              if (!half) lo_byte <= sh;
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              half   <= ~half;
              state  <= ST_WDAT;
              if (half) begin
                wr_stb  <= 1'b1;
                wr_data <= {sh, lo_byte};
              end
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              cnt <= cnt + CW'(1);
              tx  <= {tx[BYTE_W-2:0], 1'b0};
              if (cnt == CW'(BYTE_W-1)) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                sda_oe <= ~tx[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda;
            end else if (scl_fall) begin
              if (mack) begin
                half   <= ~half;
                cnt    <= '0;
                tx     <= half ? pin_lo : pin_hi;
                sda_oe <= half ? ~pin_lo[BYTE_W-1] : ~pin_hi[BYTE_W-1];
                state  <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/qpx_port_bank.sv
module qpx_port_bank #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [PW-1:0] wr_data,
  input  logic          scl_fall,
  output logic [PW-1:0] pull_low,
  output logic [PW-1:0] boost
);
  logic [PW-1:0] latch;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch <= '1;
      boost <= '0;
    end else if (wr_stb) begin
      latch <= wr_data;
      boost <= wr_data & ~latch;
    end else if (scl_fall) begin
      boost <= '0;
    end
  end

  assign pull_low = ~latch;
endmodule

// File: rtl/qpx_expander.sv
module qpx_expander #(
  parameter int BYTE_W      = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic [SEL_W-1:0]    adr_sel,
  input  logic [2*BYTE_W-1:0] pin_i,
  output logic                sda_oe,
  output logic [2*BYTE_W-1:0] pin_pull_low,
  output logic [2*BYTE_W-1:0] pin_boost
);
  localparam int PW = 2 * BYTE_W;

  logic [1:0]    bus_s;
  logic          wr_stb, scl_fall;
  logic [PW-1:0] wr_data;

  qpx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(bus_s)
  );

  qpx_i2c_slave #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_slave (
    .clk(clk), .rst(rst), .scl(bus_s[1]), .sda(bus_s[0]),
    .adr_sel(adr_sel), .pin_lvl(pin_i), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_data(wr_data), .scl_fall(scl_fall)
  );

  qpx_port_bank #(.PW(PW)) u_bank (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .scl_fall(scl_fall), .pull_low(pin_pull_low), .boost(pin_boost)
  );
endmodule

// File: rtl/qpx_checker.sv
module qpx_checker #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          sda_oe,
  input logic [PW-1:0] pin_pull_low,
  input logic [PW-1:0] pin_boost
);
  AST_RESET_RELEASE: assert property (@(posedge clk)
    rst |=> (sda_oe == 1'b0 && pin_pull_low == '0 && pin_boost == '0)); // R1

  AST_BOOST_ON_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (pin_boost & pin_pull_low) == '0); // R7

  AST_PORT_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(pin_pull_low) |-> !scl_i); // R4

  AST_SDA_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i); // R6
endmodule

bind qpx_expander qpx_checker #(.PW(2*BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .pin_pull_low(pin_pull_low), .pin_boost(pin_boost)
);

// File: tb/tb_qpx_expander.sv
`timescale 1ns/1ps
module tb_qpx_expander;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0]  adr_sel = 3'b101;
  logic [15:0] ext = 16'hFFFF;
  logic        sda_oe;
  logic [15:0] pin_pull_low, pin_boost, pin_i;
  logic        sda_line;
  logic [15:0] mdl_latch = 16'hFFFF;
  int          n_vec = 0, n_bad = 0;
  logic        ak;
  logic [7:0]  rb;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign pin_i    = ext & ~pin_pull_low;

  qpx_expander dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .adr_sel(adr_sel),
    .pin_i(pin_i), .sda_oe(sda_oe), .pin_pull_low(pin_pull_low), .pin_boost(pin_boost)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // per-clock comparison of the port drive against the model while SCL is high
  always @(negedge clk) begin
    if (!rst && scl_m) chk("R3 port model", pin_pull_low, ~mdl_latch);
  end

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start;
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q/2); b = sda_line; wq(Q/2); scl_m = 1'b0; wq(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(~mack);
  endtask

  initial begin
    wq(5);
    chk("R1 pull_low", pin_pull_low, 16'h0000);
    chk("R1 boost", pin_boost, 16'h0000);
    chk("R1 sda_oe", {15'd0, sda_oe}, 16'h0000);
    rst = 1'b0; wq(4);
    chk("R1 after release", pin_pull_low, 16'h0000);

    // single pair
    i2c_start;
    put_byte(8'h4A, ak); chk("R2 address ack", {15'd0, ak}, 16'h0001);
    put_byte(8'h12, ak);
    chk("R4 mid-pair unchanged", pin_pull_low, 16'h0000);
    put_byte(8'h34, ak); mdl_latch = 16'h3412;
    chk("R3 pair committed", pin_pull_low, ~16'h3412);
    chk("R7 no rising bits", pin_boost, 16'h0000);
    i2c_stop;

    // multi-pair burst with trailing odd byte
    i2c_start;
    put_byte(8'h4A, ak);
    put_byte(8'hFF, ak); put_byte(8'h34, ak); mdl_latch = 16'h34FF;
    chk("R7 boost on 0->1", pin_boost, 16'h00ED);
    put_byte(8'h0F, ak);
    chk("R7 boost cleared by SCL fall", pin_boost, 16'h0000);
    put_byte(8'hF0, ak); mdl_latch = 16'hF00F;
    chk("R5 second pair overwrites", pin_pull_low, ~16'hF00F);
    chk("R7 boost second pair", pin_boost, 16'hC000);
    put_byte(8'hAA, ak);
    i2c_stop;
    chk("R5 odd byte discarded", pin_pull_low, ~16'hF00F);

    // wrong address
    i2c_start;
    put_byte(8'h40, ak); chk("R2 no ack on mismatch", {15'd0, ak}, 16'h0000);
    put_byte(8'h00, ak); put_byte(8'h00, ak);
    i2c_stop;
    chk("R2 mismatch leaves ports", pin_pull_low, ~16'hF00F);

    // release all pins, then read external levels
    i2c_start;
    put_byte(8'h4A, ak); put_byte(8'hFF, ak); put_byte(8'hFF, ak); mdl_latch = 16'hFFFF;
    i2c_stop;
    chk("R10 all released", pin_pull_low, 16'h0000);
    ext = 16'hA55A;
    i2c_start;
    put_byte(8'h4B, ak); chk("R2 read address ack", {15'd0, ak}, 16'h0001);
    get_byte(1'b1, rb); chk("R6 byte0 port0", {8'd0, rb}, 16'h005A);
    get_byte(1'b1, rb); chk("R6 byte1 port1", {8'd0, rb}, 16'h00A5);
    get_byte(1'b1, rb); chk("R6 byte2 repeats port0", {8'd0, rb}, 16'h005A);
    get_byte(1'b0, rb); chk("R10 byte3 external level", {8'd0, rb}, 16'h00A5);
    chk("R11 sda released after nack", {15'd0, sda_oe}, 16'h0000);
    i2c_stop;
    ext = 16'hFFFF;

    // repeated start aborts partial pair
    i2c_start;
    put_byte(8'h4A, ak); put_byte(8'h77, ak);
    i2c_start;
    put_byte(8'h4A, ak); put_byte(8'h01, ak); put_byte(8'h02, ak); mdl_latch = 16'h0201;
    i2c_stop;
    chk("R8 abort then fresh pair", pin_pull_low, ~16'h0201);
    i2c_start;
    put_byte(8'h4A, ak); put_byte(8'h99, ak);
    i2c_start; i2c_stop;
    chk("R8 partial pair dropped", pin_pull_low, ~16'h0201);

    // reset in the middle of a byte
    i2c_start;
    put_byte(8'h4A, ak); put_bit(1'b0); put_bit(1'b0);
    mdl_latch = 16'hFFFF; rst = 1'b1; wq(3);
    sda_m = 1'b1; scl_m = 1'b1; wq(1);
    rst = 1'b0; wq(2);
    chk("R9 latches back to ones", pin_pull_low, 16'h0000);
    chk("R9 sda released", {15'd0, sda_oe}, 16'h0000);
    chk("R9 boost cleared", pin_boost, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule